// File: doc/BRIEF.md
# Clock/Parity-Line Frame Deserializer

This block takes one channel of a fast parallel input. A 24-bit word arrives on each fast sample enable, and a one-bit clock/parity line is sampled alongside it. The block collects four consecutive words into one 96-bit frame and presents the frame for a single cycle with a valid strobe. The clock/parity line carries four slots per frame. Its pattern marks the frame boundary, and its second slot holds the sender's parity bit. The block computes even parity over the assembled 96 bits and flags any disagreement with the received bit.

Frame alignment is found by hunting. While unlocked, every window whose marker pattern is wrong slips the frame boundary by one word. Lock is declared after a run of correct frames and is dropped after consecutive bad ones. Parity errors are reported only while locked. A sticky error bit collects every reported error until software clears it. The source is a free-running link that cannot be paused, so the output has no ready input. A frame that is not taken in its valid cycle is lost.

Top module: `cpline_deser`

## Requirements
- R1: On the fourth word of a frame, the next cycle shows `frm_valid` high for exactly one cycle. `frm_data[23:0]` holds the first word received and `frm_data[95:72]` holds the fourth.
- R2: While locked, a frame with a correct marker whose 96-bit XOR differs from the parity slot raises `par_err` on its valid cycle. A matching frame leaves `par_err` low.
- R3: The line slots per frame, in order, are: slot0 = 1, slot1 = parity bit, slot2 = 0, slot3 = 0. From any starting word phase, the hunt aligns the frame boundaries to this pattern.
- R4: `locked` rises together with the valid strobe of the 8th consecutive frame whose marker is correct. This holds for counter data and for pseudo-random data.
- R5: While locked, one bad marker (slot0 not 1, or slot2/slot3 not 0) keeps lock. Two consecutive bad markers drop `locked` on the second one's valid cycle.
- R6: No parity error is reported while unlocked, or for a frame whose marker is bad.
- R7: `par_err_sticky` sets together with `par_err` and holds until `sticky_clr`. A new error in the same cycle as `sticky_clr` leaves it set.
- R8: A bit-inverted clock/parity line never locks, provided the sent parity bits are not 1 for eight frames in a row.
- R9: After reset, `frm_valid`, `locked`, `par_err` and `par_err_sticky` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_en | input | 1 | Sample enable, one per input word |
| word_in | input | 24 | Input data word |
| cp_in | input | 1 | Clock/parity line sample |
| sticky_clr | input | 1 | Synchronous clear of the sticky error bit |
| frm_valid | output | 1 | One-cycle frame strobe |
| frm_data | output | 96 | Assembled frame |
| locked | output | 1 | Frame alignment locked |
| par_err | output | 1 | Parity mismatch on this frame |
| par_err_sticky | output | 1 | Accumulated parity error |

## Verification
The bench uses the default configuration: 24-bit words, four slots, a lock run of 8 and an unlock run of 2. At this size, every starting word phase (0 to 3) can be swept, and lock entry and exit can be checked to the exact frame. The parity error, the sticky bit and the clear can each be hit in a chosen frame. Counter, pseudo-random and inverted line patterns are all driven, each with expected frames computed arithmetically.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  typedef enum logic {ST_HUNT = 1'b0, ST_LOCK = 1'b1} lock_state_t;
endpackage

// File: rtl/par_tree.sv
module par_tree #(
  parameter int W     = 96,
  parameter int CHUNK = 8
) (
  input  logic [W-1:0] data,
  output logic         par
);
  localparam int NCH = (W + CHUNK - 1) / CHUNK;
  localparam int PW  = NCH * CHUNK;

  logic [PW-1:0]  padded;
  logic [NCH-1:0] part;

  assign padded = PW'(data);

  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    assign part[g] = ^padded[g*CHUNK +: CHUNK];
  end

  assign par = ^part;
endmodule

// File: rtl/cp_lock_ctrl.sv
module cp_lock_ctrl
  import cpd_pkg::*;
#(
  parameter int LOCK_N   = 8,
  parameter int UNLOCK_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_stb,
  input  logic ev_good,
  output logic locked
);
  localparam int GW = $clog2(LOCK_N + 1);
  localparam int BW = $clog2(UNLOCK_N + 1);

  lock_state_t    st_q;
  logic [GW-1:0]  good_q;
  logic [BW-1:0]  bad_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      good_q <= '0;
      bad_q  <= '0;
    end else if (ev_stb) begin
      if (st_q == ST_HUNT) begin
        bad_q <= '0;
        if (!ev_good) begin
          good_q <= '0;
        end else if (good_q == GW'(LOCK_N - 1)) begin
          good_q <= '0;
          st_q   <= ST_LOCK;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end else begin
        good_q <= '0;
        if (ev_good) begin
          bad_q <= '0;
        end else if (bad_q == BW'(UNLOCK_N - 1)) begin
          bad_q <= '0;
          st_q  <= ST_HUNT;
        end else begin
          bad_q <= bad_q + 1'b1;
        end
      end
    end
  end

  assign locked = (st_q == ST_LOCK);

  assert_lock_needs_good_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ev_stb && ev_good));
  assert_unlock_needs_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(ev_stb && !ev_good));
endmodule

// File: rtl/cpline_deser.sv
module cpline_deser #(
  parameter int WORD_W   = 24,
  parameter int WORDS    = 4,
  parameter int LOCK_N   = 8,
  parameter int UNLOCK_N = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    word_en,
  input  logic [WORD_W-1:0]       word_in,
  input  logic                    cp_in,
  input  logic                    sticky_clr,
  output logic                    frm_valid,
  output logic [WORD_W*WORDS-1:0] frm_data,
  output logic                    locked,
  output logic                    par_err,
  output logic                    par_err_sticky
);
  localparam int FW = WORD_W * WORDS;
  localparam int HW = WORD_W * (WORDS - 1);
  localparam int SW = $clog2(WORDS);

  logic [SW-1:0]    slot_q;
  logic [HW-1:0]    hist_q;
  logic [WORDS-2:0] cp_hist_q;
  logic [FW-1:0]    frame;
  logic [WORDS-1:0] cp_win;
  logic             frame_end, marker_ok, slip, calc_par, err_now;

  assign frame     = {word_in, hist_q};
  assign cp_win    = {cp_in, cp_hist_q};
  assign frame_end = word_en && (slot_q == SW'(WORDS - 1));

  always_comb begin
    marker_ok = cp_win[0];
    for (int i = 2; i < WORDS; i++) marker_ok = marker_ok && !cp_win[i];
  end

  par_tree #(.W(FW), .CHUNK(8)) u_par (.data(frame), .par(calc_par));

  cp_lock_ctrl #(.LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)) u_lock (
    .clk(clk), .rst_n(rst_n), .ev_stb(frame_end), .ev_good(marker_ok), .locked(locked)
  );

  assign slip    = frame_end && !locked && !marker_ok;
  assign err_now = frame_end && locked && marker_ok && (calc_par != cp_win[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q    <= '0;
      hist_q    <= '0;
      cp_hist_q <= '0;
    end else if (word_en) begin
      hist_q    <= {word_in, hist_q[HW-1:WORD_W]};
      cp_hist_q <= {cp_in, cp_hist_q[WORDS-2:1]};
      if (frame_end) slot_q <= slip ? slot_q : '0;
      else           slot_q <= slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_valid      <= 1'b0;
      frm_data       <= '0;
      par_err        <= 1'b0;
      par_err_sticky <= 1'b0;
    end else begin
      frm_valid      <= frame_end && (locked || marker_ok);
      if (frame_end) frm_data <= frame;
      par_err        <= err_now;
      par_err_sticky <= (par_err_sticky && !sticky_clr) || err_now;
    end
  end

  assert_valid_after_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> $past(word_en));
  assert_valid_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid);
  assert_err_with_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> frm_valid);
  assert_err_only_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $past(locked));
  assert_sticky_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err_sticky) |-> par_err);
endmodule

// File: tb/cpline_deser_test.sv
module cpline_deser_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_en = 1'b0;
  logic [23:0] word_in = '0;
  logic        cp_in = 1'b0;
  logic        sticky_clr = 1'b0;
  logic        frm_valid, locked, par_err, par_err_sticky;
  logic [95:0] frm_data;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cpline_deser uut (
    .clk(clk), .rst_n(rst_n), .word_en(word_en), .word_in(word_in), .cp_in(cp_in),
    .sticky_clr(sticky_clr), .frm_valid(frm_valid), .frm_data(frm_data),
    .locked(locked), .par_err(par_err), .par_err_sticky(par_err_sticky)
  );

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        report();
      end
    end
  end

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    word_en = 1'b0;
    sticky_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic put_word(input logic [23:0] w, input logic cp, input logic clr);
    @(negedge clk);
    word_en = 1'b1;
    word_in = w;
    cp_in = cp;
    sticky_clr = clr;
    @(negedge clk);
    word_en = 1'b0;
    sticky_clr = 1'b0;
  endtask

  // cp bit i goes with word i; the last clr flag applies with the fourth word
  task automatic send_frame(input logic [95:0] d, input logic [3:0] cp, input logic clr);
    for (int i = 0; i < 4; i++) put_word(d[i*24 +: 24], cp[i], (i == 3) ? clr : 1'b0);
  endtask

  function automatic logic [3:0] cp_of(input logic [95:0] d, input logic flip);
    return {1'b0, 1'b0, (^d) ^ flip, 1'b1};
  endfunction

  function automatic logic [95:0] cnt_frame(input int k);
    return {24'(4*k+3), 24'(4*k+2), 24'(4*k+1), 24'(4*k)};
  endfunction

  function automatic logic [31:0] xs32(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  logic [95:0] d;
  logic [31:0] seed;
  bit any_lock, any_err, seq_ok;

  initial begin
    do_reset();
    @(negedge clk);
    chk(frm_valid == 0, "R9 valid", 96'(frm_valid), 0);
    chk(locked == 0, "R9 locked", 96'(locked), 0);
    chk(par_err == 0, "R9 err", 96'(par_err), 0);
    chk(par_err_sticky == 0, "R9 sticky", 96'(par_err_sticky), 0);

    // aligned counter pattern: packing and exact lock frame
    for (int k = 0; k < 12; k++) begin
      d = cnt_frame(k);
      send_frame(d, cp_of(d, 0), 0);
      chk(frm_valid == 1, "R1 valid", 96'(frm_valid), 1);
      chk(frm_data == d, "R1 data", frm_data, d);
      chk(locked == (k >= 7), "R4 lock frame", 96'(locked), 96'(k >= 7));
      chk(par_err == 0, "R2 no err", 96'(par_err), 0);
    end
    @(negedge clk);
    chk(frm_valid == 0, "R1 one cycle", 96'(frm_valid), 0);

    // parity error while locked
    d = cnt_frame(12);
    send_frame(d, cp_of(d, 1), 0);
    chk(par_err == 1, "R2 mismatch", 96'(par_err), 1);
    chk(par_err_sticky == 1, "R7 sticky set", 96'(par_err_sticky), 1);
    d = cnt_frame(13);
    send_frame(d, cp_of(d, 0), 0);
    chk(par_err == 0, "R2 clean", 96'(par_err), 0);
    chk(par_err_sticky == 1, "R7 sticky hold", 96'(par_err_sticky), 1);
    @(negedge clk);
    sticky_clr = 1'b1;
    @(negedge clk);
    sticky_clr = 1'b0;
    chk(par_err_sticky == 0, "R7 clear", 96'(par_err_sticky), 0);
    d = cnt_frame(14);
    send_frame(d, cp_of(d, 1), 1);
    chk(par_err_sticky == 1, "R7 clear vs set", 96'(par_err_sticky), 1);
    @(negedge clk);
    sticky_clr = 1'b1;
    @(negedge clk);
    sticky_clr = 1'b0;

    // one bad marker (with wrong parity too) keeps lock, no error
    d = cnt_frame(15);
    send_frame(d, cp_of(d, 1) & 4'b1110, 0);
    chk(locked == 1, "R5 one bad", 96'(locked), 1);
    chk(par_err == 0, "R6 bad marker no err", 96'(par_err), 0);
    d = cnt_frame(16);
    send_frame(d, cp_of(d, 0), 0);
    chk(locked == 1, "R5 recover", 96'(locked), 1);
    d = cnt_frame(17);
    send_frame(d, cp_of(d, 0) | 4'b1000, 0);
    chk(locked == 1, "R5 first bad", 96'(locked), 1);
    d = cnt_frame(18);
    send_frame(d, cp_of(d, 0) | 4'b0100, 0);
    chk(locked == 0, "R5 second bad", 96'(locked), 0);

    // unlocked: wrong parity suppressed, relock on 8th good
    any_err = 0;
    for (int k = 19; k < 26; k++) begin
      d = cnt_frame(k);
      send_frame(d, cp_of(d, 1), 0);
      if (par_err || locked) any_err = 1;
    end
    chk(any_err == 0, "R6 suppressed", 96'(any_err), 0);
    d = cnt_frame(26);
    send_frame(d, cp_of(d, 1), 0);
    chk(locked == 1 && par_err == 0, "R4 relock", {94'b0, locked, par_err}, 96'b10);
    d = cnt_frame(27);
    send_frame(d, cp_of(d, 1), 0);
    chk(par_err == 1, "R2 after relock", 96'(par_err), 1);

    // phase sweep: junk words ahead of the first frame
    for (int off = 0; off < 4; off++) begin
      do_reset();
      for (int j = 0; j < off; j++) put_word(24'hA00000 + 24'(j), 1'b0, 1'b0);
      seq_ok = 1;
      any_err = 0;
      for (int k = 0; k < 14; k++) begin
        d = cnt_frame(k);
        send_frame(d, cp_of(d, 0), 0);
        if (frm_valid) begin
          if (frm_data[1:0] != 2'b00) seq_ok = 0;
          for (int w = 1; w < 4; w++)
            if (frm_data[w*24 +: 24] != frm_data[23:0] + 24'(w)) seq_ok = 0;
        end
        if (par_err) any_err = 1;
      end
      chk(locked == 1, $sformatf("R3 lock phase %0d", off), 96'(locked), 1);
      chk(seq_ok, $sformatf("R3 aligned phase %0d", off), 96'(seq_ok), 1);
      chk(any_err == 0, $sformatf("R6 hunt err phase %0d", off), 96'(any_err), 0);
    end

    // pseudo-random data
    do_reset();
    seed = 32'h1234_5678;
    any_err = 0;
    seq_ok = 1;
    for (int k = 0; k < 12; k++) begin
      seed = xs32(seed); d[31:0] = seed;
      seed = xs32(seed); d[63:32] = seed;
      seed = xs32(seed); d[95:64] = seed;
      send_frame(d, cp_of(d, 0), 0);
      if (!frm_valid || frm_data != d) seq_ok = 0;
      if (par_err) any_err = 1;
    end
    chk(locked == 1, "R4 random lock", 96'(locked), 1);
    chk(seq_ok, "R1 random data", 96'(seq_ok), 1);
    chk(any_err == 0, "R2 random no err", 96'(any_err), 0);

    // inverted line with alternating parity
    do_reset();
    any_lock = 0;
    for (int k = 0; k < 40; k++) begin
      d = cnt_frame(k);
      if ((^d) != k[0]) d[95] = ~d[95];
      send_frame(d, ~cp_of(d, 0), 0);
      if (locked) any_lock = 1;
    end
    chk(any_lock == 0, "R8 inverted never locks", 96'(any_lock), 0);

    report();
  end
endmodule